// File: doc/BRIEF.md
# Line Code Violation Counter

This block counts line coding errors on a received bipolar T1 or E1 stream. Each bit slot arrives as a positive-mark and a negative-mark indication qualified by a bit strobe. The block tracks mark polarity and finds bipolar violations, which are marks that repeat the polarity of the previous mark. Depending on the mode, it either counts those violations directly or counts only code violations. It does not count the deliberate violations inside valid zero-substitution codewords. It can also add one event for each excessive run of zeros.

Events go into a saturating 16-bit accumulator. The update strobe comes from a one-second, 42 ms or 62.5 ms timer, or from a manual request, and is muxed outside the block. On that strobe the running total is copied into a register the host can read, and the accumulator starts a fresh interval in the same cycle. Counting never depends on frame alignment, so it continues through loss of synchronisation.

Top module: `lcv_counter`

## Requirements
- R1: After reset, `held_count` is 0, `upd_pulse` is 0 and the running total is empty.
- R2: A slot is a mark only when exactly one of `pos_mark` and `neg_mark` is high, and its polarity is positive when `pos_mark` is high. Both high or both low is a zero. Pin levels are ignored in any cycle where `bit_en` is low.
- R3: A mark whose polarity equals that of the previous mark is a bipolar violation. When `cv_mode` is 0, every violation that is not excluded adds one. The credit lands at the 8th bit strobe after the strobe that carried the violation.
- R4: When `cv_mode` is 1, a surviving violation adds one only if the previous surviving violation had the same polarity. The first surviving violation after reset adds nothing.
- R5: When `t1_mode`=1 and `zsub_en`=1, eight slots that read zero, zero, zero, V, B, zero, V, B are a codeword. The two V marks must be violations, each B must have the opposite polarity to the V before it, and the second V must repeat the first B. Neither V is counted.
- R6: When `t1_mode`=0 and `zsub_en`=1, a violation whose two preceding slots are both zero (the 000V and B00V forms) is not counted. With `zsub_en`=0 no violation is excluded.
- R7: When `exz_en`=1, a zero run adds one at the strobe where it reaches 8 zeros (`zsub_en`=1) or 16 zeros (`zsub_en`=0). A run counts once however long it lasts, and a mark ends the run.
- R8: The running total saturates at 65,535 and never wraps.
- R9: On `snap_req`, `held_count` takes the running total and the total restarts from the events of that same cycle. `upd_pulse` is high on the following cycle, when the new `held_count` is first visible. `held_count` changes at no other time.
- R10: A violation credit and an excessive-zero event on the same strobe add two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies one received bit slot |
| pos_mark | input | 1 | Positive mark seen in this slot |
| neg_mark | input | 1 | Negative mark seen in this slot |
| t1_mode | input | 1 | 1 = T1 rules, 0 = E1 rules |
| zsub_en | input | 1 | Zero-substitution codewords expected |
| cv_mode | input | 1 | 1 = count code violations, 0 = bipolar violations |
| exz_en | input | 1 | Add excessive-zero runs to the count |
| snap_req | input | 1 | Interval end: latch total and restart |
| held_count | output | 16 | Total of the last closed interval |
| upd_pulse | output | 1 | High for the cycle after a snapshot |

## Verification
A polarity register that goes wrong shifts the violation decisions. A corrupt flag in the eight-stage delay line does the same, and either shows up as a wrong `held_count` at the next snapshot, up to one interval after the event. A codeword matcher misaligned by one slot lets both V marks through, so each substitution adds two. A zero-run counter that restarts too late or too early adds or loses excessive-zero events. None of these errors is visible until `upd_pulse` fires, so the bench closes intervals often, typically every few dozen strobes. It compares against a behavioural model on every clock so that a fault is pinned to the interval in which it occurred.

// File: rtl/lcv_pkg.sv
package lcv_pkg;

  // One received bit slot: mark present, and its polarity (1 = positive).
  typedef struct packed {
    logic mark;
    logic pos;
  } slot_t;

  // Decision delay: a violation is held this many strobes so that a T1
  // codeword finishing after it can still cancel it.
  localparam int unsigned HOLD_D = 8;

endpackage

// File: rtl/lcv_classify.sv
module lcv_classify
  import lcv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  slot_t slot_in,
  input  logic  t1_mode,
  input  logic  zsub_en,
  input  logic  cv_mode,
  output logic  viol_evt
);

  localparam int unsigned HW = HOLD_D - 1;

  slot_t [HW-1:0]     hist_q, hist_d;
  logic  [HOLD_D-1:0] vflag_q, vflag_d;
  logic  [HOLD_D-1:0] vpol_q,  vpol_d;
  logic               have_last_q, have_last_d;
  logic               last_pos_q,  last_pos_d;
  logic               have_lv_q,   have_lv_d;
  logic               lv_pos_q,    lv_pos_d;

  slot_t              win [HOLD_D];
  logic  [HOLD_D-1:0] sflag;
  logic               bpv, b8_hit, hd_hit, leaving, leave_pos;

  assign win[0] = slot_in;
  for (genvar g = 1; g < HOLD_D; g++) begin : g_win
    assign win[g] = hist_q[g-1];
  end

  assign bpv       = slot_in.mark && have_last_q && (slot_in.pos == last_pos_q);
  assign sflag     = {vflag_q[HOLD_D-2:0], bpv};
  assign leaving   = vflag_q[HOLD_D-1];
  assign leave_pos = vpol_q[HOLD_D-1];

  // T1 window, oldest first: 0 0 0 V B 0 V B
  assign b8_hit = t1_mode && zsub_en &&
                  !win[7].mark && !win[6].mark && !win[5].mark &&
                  win[4].mark && win[3].mark && (win[3].pos != win[4].pos) &&
                  !win[2].mark && win[1].mark && (win[1].pos == win[3].pos) &&
                  win[0].mark && (win[0].pos != win[1].pos) &&
                  sflag[4] && sflag[1];

  // E1: a violation right after two zeros closes 000V or B00V
  assign hd_hit = !t1_mode && zsub_en && bpv && !win[1].mark && !win[2].mark;

  always_comb begin
    hist_d      = hist_q;
    vflag_d     = vflag_q;
    vpol_d      = vpol_q;
    have_last_d = have_last_q;
    last_pos_d  = last_pos_q;
    have_lv_d   = have_lv_q;
    lv_pos_d    = lv_pos_q;
    viol_evt    = 1'b0;
    if (bit_en) begin
      hist_d  = {hist_q[HW-2:0], slot_in};
      vpol_d  = {vpol_q[HOLD_D-2:0], slot_in.pos};
      vflag_d = sflag;
      if (b8_hit) begin
        vflag_d[4] = 1'b0;
        vflag_d[1] = 1'b0;
      end
      if (hd_hit) begin
        vflag_d[0] = 1'b0;
      end
      if (slot_in.mark) begin
        have_last_d = 1'b1;
        last_pos_d  = slot_in.pos;
      end
      if (leaving) begin
        viol_evt  = !cv_mode || (have_lv_q && (lv_pos_q == leave_pos));
        have_lv_d = 1'b1;
        lv_pos_d  = leave_pos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q      <= '0;
      vflag_q     <= '0;
      vpol_q      <= '0;
      have_last_q <= 1'b0;
      last_pos_q  <= 1'b0;
      have_lv_q   <= 1'b0;
      lv_pos_q    <= 1'b0;
    end else if (bit_en) begin
      hist_q      <= hist_d;
      vflag_q     <= vflag_d;
      vpol_q      <= vpol_d;
      have_last_q <= have_last_d;
      last_pos_q  <= last_pos_d;
      have_lv_q   <= have_lv_d;
      lv_pos_q    <= lv_pos_d;
    end
  end

endmodule

// File: rtl/lcv_zero_run.sv
module lcv_zero_run #(
  parameter int unsigned LONG_RUN  = 16,
  parameter int unsigned SHORT_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark,
  input  logic zsub_en,
  input  logic exz_en,
  output logic ez_evt
);

  localparam int unsigned RW = $clog2(LONG_RUN + 1);

  logic [RW-1:0] run_q, run_d, limit, run_inc;

  assign limit   = zsub_en ? RW'(SHORT_RUN) : RW'(LONG_RUN);
  assign run_inc = run_q + RW'(1);

  always_comb begin
    run_d  = run_q;
    ez_evt = 1'b0;
    if (bit_en) begin
      if (mark) begin
        run_d = '0;
      end else if (run_q < limit) begin
        run_d  = run_inc;
        ez_evt = exz_en && (run_inc == limit);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (bit_en) begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/lcv_accum.sv
module lcv_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_req,
  input  logic [1:0]       inc,
  output logic [CNT_W-1:0] acc_q,
  output logic [CNT_W-1:0] held_q,
  output logic             pulse_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] acc_d;
  logic             acc_en;

  assign sum    = {1'b0, acc_q} + {{(CNT_W-1){1'b0}}, inc};
  assign acc_en = snap_req || (inc != 2'd0);

  always_comb begin
    if (snap_req) begin
      acc_d = {{(CNT_W-2){1'b0}}, inc};
    end else if (sum[CNT_W]) begin
      acc_d = CNT_MAX;
    end else begin
      acc_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (snap_req) begin
      held_q <= acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= snap_req;
    end
  end

endmodule

// File: rtl/lcv_counter.sv
module lcv_counter
  import lcv_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LONG_RUN  = 16,
  parameter int unsigned SHORT_RUN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             pos_mark,
  input  logic             neg_mark,
  input  logic             t1_mode,
  input  logic             zsub_en,
  input  logic             cv_mode,
  input  logic             exz_en,
  input  logic             snap_req,
  output logic [CNT_W-1:0] held_count,
  output logic             upd_pulse
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  slot_t            slot;
  logic             viol_evt, ez_evt;
  logic [1:0]       inc;
  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign slot.mark = pos_mark ^ neg_mark;
  assign slot.pos  = pos_mark;
  assign inc       = {1'b0, viol_evt} + {1'b0, ez_evt};

  lcv_classify u_classify (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .slot_in  (slot),
    .t1_mode  (t1_mode),
    .zsub_en  (zsub_en),
    .cv_mode  (cv_mode),
    .viol_evt (viol_evt)
  );

  lcv_zero_run #(
    .LONG_RUN  (LONG_RUN),
    .SHORT_RUN (SHORT_RUN)
  ) u_zero_run (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_en  (bit_en),
    .mark    (slot.mark),
    .zsub_en (zsub_en),
    .exz_en  (exz_en),
    .ez_evt  (ez_evt)
  );

  lcv_accum #(
    .CNT_W (CNT_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .snap_req (snap_req),
    .inc      (inc),
    .acc_q    (acc_cnt),
    .held_q   (held_count),
    .pulse_q  (upd_pulse)
  );

endmodule

// File: rtl/lcv_counter_chk.sv
module lcv_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             bit_en,
  input logic             snap_req,
  input logic             upd_pulse,
  input logic [CNT_W-1:0] held_count,
  input logic [CNT_W-1:0] acc_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W+1:0] acc_x;
  assign acc_x = {2'b00, acc_q};

  p_pulse_after_req_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    snap_req |=> upd_pulse);

  p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !snap_req |=> !upd_pulse);

  p_held_moves_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(held_count) |-> upd_pulse);

  p_restart_small_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    snap_req |=> (acc_x <= (CNT_W+2)'(2)));

  p_idle_frozen_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bit_en && !snap_req) |=> $stable(acc_q));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_q == CNT_MAX && !snap_req) |=> (acc_q == CNT_MAX));

  p_step_bound_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !snap_req |=> ((acc_x >= $past(acc_x)) && (acc_x <= $past(acc_x) + (CNT_W+2)'(2))));

endmodule

bind lcv_counter lcv_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .bit_en     (bit_en),
  .snap_req   (snap_req),
  .upd_pulse  (upd_pulse),
  .held_count (held_count),
  .acc_q      (acc_cnt)
);

// File: tb/lcv_counter_tb_top.sv
module lcv_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, pos_mark = 1'b0, neg_mark = 1'b0;
  logic        t1_mode = 1'b1, zsub_en = 1'b0, cv_mode = 1'b0, exz_en = 1'b0;
  logic        snap_req = 1'b0;
  logic [15:0] held_count;
  logic        upd_pulse;

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  lcv_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pos_mark(pos_mark),
    .neg_mark(neg_mark), .t1_mode(t1_mode), .zsub_en(zsub_en),
    .cv_mode(cv_mode), .exz_en(exz_en), .snap_req(snap_req),
    .held_count(held_count), .upd_pulse(upd_pulse)
  );

  // ---------------- behavioural reference ----------------
  typedef struct { bit v; bit p; } vrec_t;
  vrec_t vq[$];
  int    sq[$];      // 0 zero, 1 positive, 2 negative; newest at back
  int    m_held, m_acc, m_zr;
  bit    m_pulse, m_hl, m_lp, m_hlv, m_lvp;

  task automatic model_reset();
    vq.delete(); sq.delete();
    for (int i = 0; i < 8; i++) vq.push_back('{1'b0, 1'b0});
    for (int i = 0; i < 7; i++) sq.push_back(0);
    m_held = 0; m_acc = 0; m_zr = 0; m_pulse = 0;
    m_hl = 0; m_lp = 0; m_hlv = 0; m_lvp = 0;
  endtask

  task automatic model_step();
    int    inc = 0;
    bit    mk, pp, v;
    int    s, thr;
    vrec_t e;
    if (bit_en) begin
      mk = pos_mark ^ neg_mark;
      pp = pos_mark;
      s  = mk ? (pp ? 1 : 2) : 0;
      v  = mk && m_hl && (pp == m_lp);
      if (mk) begin m_hl = 1; m_lp = pp; end
      e = vq.pop_front();
      if (e.v) begin
        if (!cv_mode || (m_hlv && m_lvp == e.p)) inc++;
        m_hlv = 1; m_lvp = e.p;
      end
      vq.push_back('{v, pp});
      sq.push_back(s);
      if (t1_mode && zsub_en && sq[0] == 0 && sq[1] == 0 && sq[2] == 0 &&
          sq[3] != 0 && sq[4] != 0 && sq[4] != sq[3] && sq[5] == 0 &&
          sq[6] == sq[4] && sq[7] != 0 && sq[7] != sq[6] &&
          vq[3].v && vq[6].v) begin
        vq[3].v = 0; vq[6].v = 0;
      end
      if (!t1_mode && zsub_en && v && sq[6] == 0 && sq[5] == 0) vq[7].v = 0;
      void'(sq.pop_front());
      thr = zsub_en ? 8 : 16;
      if (mk) m_zr = 0;
      else if (m_zr < thr) begin
        m_zr++;
        if (m_zr == thr && exz_en) inc++;
      end
    end
    if (snap_req) begin
      m_held = m_acc; m_acc = inc;
    end else begin
      m_acc += inc;
      if (m_acc > 65535) m_acc = 65535;
    end
    m_pulse = snap_req;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (held_count !== 16'(m_held) || upd_pulse !== m_pulse) begin
        n_bad++;
        $display("FAIL %s: held_count=%0d upd_pulse=%0b expected held_count=%0d upd_pulse=%0b",
                 phase, held_count, upd_pulse, m_held, m_pulse);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(bit en, byte c, bit snap);
    @(negedge clk);
    bit_en   = en;
    pos_mark = (c == "P" || c == "B");
    neg_mark = (c == "N" || c == "B");
    snap_req = snap;
  endtask

  task automatic seq(string s);
    for (int i = 0; i < s.len(); i++) tick(1'b1, s[i], 1'b0);
    tick(1'b0, "0", 1'b0);
  endtask

  task automatic flush_snap();
    for (int i = 0; i < 9; i++) tick(1'b1, "0", 1'b0);
    tick(1'b0, "0", 1'b1);
    tick(1'b0, "0", 1'b0);
    tick(1'b0, "0", 1'b0);
  endtask

  task automatic modes(bit t1, bit zs, bit cv, bit ez);
    @(negedge clk);
    bit_en = 0; snap_req = 0;
    t1_mode = t1; zsub_en = zs; cv_mode = cv; exz_en = ez;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_on = 1'b1;               // R1: reset state compared from here
    rst_n  = 1'b1;
    repeat (5) @(negedge clk);
    phase = "R1";
    tick(1'b0, "0", 1'b1);
    tick(1'b0, "0", 1'b0);

    phase = "R3";                // plain bipolar violations
    modes(1, 0, 0, 0);
    seq("PNPPNNPN0PP0NN");
    flush_snap();

    phase = "R2";                // strobe-low junk and both-high slots
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      bit_en = 0; pos_mark = 1'($urandom); neg_mark = 1'($urandom); snap_req = 0;
    end
    seq("PBPNBN0BPP");
    flush_snap();

    phase = "R5";                // B8ZS codewords
    modes(1, 1, 0, 0);
    seq("P000PN0NP");
    seq("N000NP0PN");
    seq("P000PN0NN");            // near miss: counted
    flush_snap();
    modes(1, 0, 0, 0);
    seq("P000PN0NP");            // zsub off: both violations counted
    flush_snap();

    phase = "R6";                // HDB3 forms
    modes(0, 1, 0, 0);
    seq("P000P");
    seq("N00N");
    seq("PN00N");
    seq("P0P");                  // one zero only: counted
    flush_snap();
    modes(0, 0, 0, 0);
    seq("P000PN00N");
    flush_snap();

    phase = "R4";                // code violations
    modes(1, 0, 1, 0);
    seq("PPNNPPPNN");
    seq("PPPP");
    flush_snap();

    phase = "R7";                // excessive zeros
    modes(1, 1, 0, 1);
    seq({"P", {7{"0"}}, "N", {8{"0"}}, "P", {20{"0"}}, "N"});
    modes(1, 0, 0, 1);
    seq({"P", {15{"0"}}, "N", {16{"0"}}, "P", {40{"0"}}, "N"});
    modes(0, 1, 0, 1);
    seq({"P", {9{"0"}}, "N"});
    flush_snap();

    phase = "R10";               // violation credit meets zero-run event
    modes(1, 1, 0, 1);
    seq({"PP", {8{"0"}}, "N"});
    flush_snap();

    phase = "R9";                // snapshot coinciding with events
    modes(1, 0, 0, 0);
    seq("PPPPPPP");
    for (int i = 0; i < 6; i++) tick(1'b1, "0", (i == 2));
    tick(1'b0, "0", 1'b1);
    tick(1'b0, "0", 1'b1);
    tick(1'b0, "0", 1'b0);

    phase = "R8";                // saturation
    modes(1, 0, 0, 0);
    for (int i = 0; i < 65600; i++) tick(1'b1, "P", 1'b0);
    tick(1'b0, "0", 1'b1);
    for (int i = 0; i < 20; i++) tick(1'b1, "P", 1'b0);
    tick(1'b0, "0", 1'b1);
    tick(1'b0, "0", 1'b0);

    phase = "R3";                // mixed random traffic, all rules active
    for (int blk = 0; blk < 40; blk++) begin
      modes(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 150; i++) begin
        int  r = $urandom_range(0, 9);
        byte c = (r < 5) ? "0" : (r < 7) ? "P" : (r < 9) ? "N" : "B";
        tick(($urandom_range(0, 7) != 0), c, ($urandom_range(0, 39) == 0));
      end
    end
    flush_snap();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (%s): run still active, expected completion", phase);
      summary();
      $finish;
    end
  end

endmodule